// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block is the fetch-and-retire engine on the DMA side of a transmit path. Descriptors sit in a memory as one 64-bit word each, starting at a ring base address. Software loads the base and pulses a start strobe. The engine then reads the descriptor at the current index. If the engine does not own it, the engine parks in a suspended state. If it owns it, the engine requests up to two buffers from the fetch side and tags each request with frame boundary flags. It then writes the descriptor back with the ownership bit cleared and an error summary filled in. If the descriptor asks for it, the engine raises an interrupt pulse.

The ring has no fixed length. A wrap flag inside a descriptor sends the engine back to the base once that descriptor has been retired. A poll strobe wakes a suspended engine at the index where it stopped. A software reset strobe returns the engine to idle, and a busy flag stays high for a fixed number of cycles while the reset completes.

Descriptor word layout, bit 63 down to 0:
- [63] owned by engine
- [62] wrap to base
- [61] frame start
- [60] frame end
- [59] interrupt request
- [58] error summary
- [57:45] size of buffer 2
- [44:32] size of buffer 1
- [31:16] address of buffer 2
- [15:0] address of buffer 1

Descriptor addresses count words, so descriptor index i lives at base + i.

Top module: `tx_ring_walker`

## Requirements
- R1: When start_i is pulsed in idle with rst_busy_o low, the next descriptor read (desc_rd_o high for one cycle) uses desc_addr_o equal to ring_base_i. The read data is taken from desc_rdata_i one cycle after desc_rd_o.
- R2: If a fetched descriptor has bit 63 clear, suspended_o goes high. While suspended, the engine issues no buffer request, no descriptor read and no descriptor write.
- R3: A poll_i pulse while suspended refetches the descriptor at the same index where the engine stopped.
- R4: For an owned descriptor, the engine issues a buffer request for buffer 1 (address [15:0], size [44:32]) and then one for buffer 2 (address [31:16], size [57:45]). A buffer whose size is zero gets no request.
- R5: buf_first_o is high only on the first request of a descriptor with bit 61 set. buf_last_o is high only on the last request of a descriptor with bit 60 set.
- R6: After the last request is granted, or directly after the fetch when both sizes are zero, the engine writes back to the same address. The written word has bit 63 cleared, bit 58 equal to the OR of buf_err_i over that descriptor's grants, and every other bit unchanged.
- R7: tx_irq_o pulses for one cycle during the write-back of a descriptor whose bit 59 is set, and at no other time.
- R8: After write-back, the index returns to 0 (address ring_base_i) when bit 62 is set. Otherwise it advances by one.
- R9: A sw_rst_i pulse sends the engine to idle and clears the index. rst_busy_o then stays high for RST_CYCLES cycles, and during that time start_i is ignored and no memory access occurs.
- R10: While rst_ni is low, every output is low.
- R11: A buffer request stays asserted with a stable address and size until buf_gnt_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ring_base_i | input | 16 | Ring base address, latched at start |
| start_i | input | 1 | Start strobe, accepted in idle |
| poll_i | input | 1 | Poll strobe, resumes from suspend |
| sw_rst_i | input | 1 | Software reset strobe |
| rst_busy_o | output | 1 | High while software reset is in progress |
| suspended_o | output | 1 | Engine stopped on a descriptor it does not own |
| desc_rd_o | output | 1 | Descriptor read strobe |
| desc_wr_o | output | 1 | Descriptor write-back strobe |
| desc_addr_o | output | 16 | Descriptor word address |
| desc_rdata_i | input | 64 | Descriptor read data, one cycle after desc_rd_o |
| desc_wdata_o | output | 64 | Descriptor write-back data |
| buf_req_o | output | 1 | Buffer read request |
| buf_addr_o | output | 16 | Buffer address |
| buf_len_o | output | 13 | Buffer size in bytes |
| buf_first_o | output | 1 | Request opens a frame |
| buf_last_o | output | 1 | Request closes a frame |
| buf_gnt_i | input | 1 | Buffer request accepted |
| buf_err_i | input | 1 | Error on the accepted request, valid with buf_gnt_i |
| tx_irq_o | output | 1 | Transmit completion interrupt pulse |

## Verification
A wrong index or a lost wrap shows up at the ports within a single descriptor. The next desc_addr_o read address is then wrong, and on a ring whose wrap descriptor has just been retired, the engine fails to suspend on the base entry. A stale error accumulator or a wrong captured descriptor shows up as a corrupted write-back word or as wrong boundary flags on the very next request. Wrong suspend or reset state shows up as memory traffic in cycles where there must be none. The stimulus therefore compares every request, every read address and every write-back word against values worked out from the descriptor layout. It does this under grant delays of zero, one and two cycles.

// File: rtl/txw_pkg.sv
package txw_pkg;
  localparam int ADDR_W = 16;
  localparam int LEN_W  = 13;
  localparam int DESC_W = 64;

  typedef struct packed {
    logic              own;
    logic              wrap;
    logic              first;
    logic              last;
    logic              irq;
    logic              err;
    logic [LEN_W-1:0]  b2_len;
    logic [LEN_W-1:0]  b1_len;
    logic [ADDR_W-1:0] b2_addr;
    logic [ADDR_W-1:0] b1_addr;
  } desc_t;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_WAIT, S_BUF1, S_BUF2, S_WB, S_SUSP
  } state_e;
endpackage

// File: rtl/txw_ring_ptr.sv
module txw_ring_ptr #(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              adv_i,
  input  logic              wrap_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] base_q;
  logic [IDX_W-1:0]  idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      idx_q  <= '0;
    end else if (clr_i) begin
      idx_q  <= '0;
    end else if (load_i) begin
      base_q <= base_i;
      idx_q  <= '0;
    end else if (adv_i) begin
      idx_q  <= wrap_i ? '0 : idx_q + 1'b1;
    end
  end

  assign addr_o = base_q + ADDR_W'(idx_q);
endmodule

// File: rtl/txw_rst_ctl.sv
module txw_rst_ctl #(
  parameter int RST_CYCLES = 4,
  localparam int CNT_W = $clog2(RST_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sw_rst_i,
  output logic busy_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (sw_rst_i)    cnt_q <= CNT_W'(RST_CYCLES);
    else if (cnt_q != 0)  cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != 0);
endmodule

// File: rtl/tx_ring_walker.sv
module tx_ring_walker
  import txw_pkg::*;
#(
  parameter int IDX_W      = 8,
  parameter int RST_CYCLES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] ring_base_i,
  input  logic              start_i,
  input  logic              poll_i,
  input  logic              sw_rst_i,
  output logic              rst_busy_o,
  output logic              suspended_o,
  output logic              desc_rd_o,
  output logic              desc_wr_o,
  output logic [ADDR_W-1:0] desc_addr_o,
  input  logic [DESC_W-1:0] desc_rdata_i,
  output logic [DESC_W-1:0] desc_wdata_o,
  output logic              buf_req_o,
  output logic [ADDR_W-1:0] buf_addr_o,
  output logic [LEN_W-1:0]  buf_len_o,
  output logic              buf_first_o,
  output logic              buf_last_o,
  input  logic              buf_gnt_i,
  input  logic              buf_err_i,
  output logic              tx_irq_o
);
  state_e state_q, state_d;
  desc_t  desc_q, rd_desc, wb_desc;
  logic   err_q;
  logic   busy;
  logic   start_ok;

  assign rd_desc  = desc_t'(desc_rdata_i);
  assign start_ok = (state_q == S_IDLE) && start_i && !busy && !sw_rst_i;

  txw_rst_ctl #(.RST_CYCLES(RST_CYCLES)) u_rst (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sw_rst_i (sw_rst_i),
    .busy_o   (busy)
  );

  txw_ring_ptr #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_ptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (sw_rst_i),
    .load_i (start_ok),
    .base_i (ring_base_i),
    .adv_i  (state_q == S_WB),
    .wrap_i (desc_q.wrap),
    .addr_o (desc_addr_o)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:  if (start_ok) state_d = S_FETCH;
      S_FETCH: state_d = S_WAIT;
      S_WAIT: begin
        if (!rd_desc.own)            state_d = S_SUSP;
        else if (rd_desc.b1_len != 0) state_d = S_BUF1;
        else if (rd_desc.b2_len != 0) state_d = S_BUF2;
        else                          state_d = S_WB;
      end
      S_BUF1:  if (buf_gnt_i) state_d = (desc_q.b2_len != 0) ? S_BUF2 : S_WB;
      S_BUF2:  if (buf_gnt_i) state_d = S_WB;
      S_WB:    state_d = S_FETCH;
      S_SUSP:  if (poll_i) state_d = S_FETCH;
      default: state_d = S_IDLE;
    endcase
    if (sw_rst_i || busy) state_d = S_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      desc_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == S_WAIT) begin
        desc_q <= rd_desc;
        err_q  <= 1'b0;
      end else if (buf_req_o && buf_gnt_i) begin
        err_q  <= err_q | buf_err_i;
      end
    end
  end

  always_comb begin
    wb_desc     = desc_q;
    wb_desc.own = 1'b0;
    wb_desc.err = err_q;
  end

  assign rst_busy_o   = busy;
  assign suspended_o  = (state_q == S_SUSP);
  assign desc_rd_o    = (state_q == S_FETCH);
  assign desc_wr_o    = (state_q == S_WB);
  assign desc_wdata_o = wb_desc;
  assign tx_irq_o     = (state_q == S_WB) && desc_q.irq;

  assign buf_req_o   = (state_q == S_BUF1) || (state_q == S_BUF2);
  assign buf_addr_o  = (state_q == S_BUF2) ? desc_q.b2_addr : desc_q.b1_addr;
  assign buf_len_o   = (state_q == S_BUF2) ? desc_q.b2_len  : desc_q.b1_len;
  // first request: buffer 1, or buffer 2 when buffer 1 was skipped
  assign buf_first_o = buf_req_o && desc_q.first &&
                       ((state_q == S_BUF1) || (desc_q.b1_len == 0));
  assign buf_last_o  = buf_req_o && desc_q.last &&
                       ((state_q == S_BUF2) || (desc_q.b2_len == 0));
endmodule

// File: rtl/tx_ring_walker_chk.sv
module tx_ring_walker_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        sw_rst_i,
  input logic        rst_busy_o,
  input logic        suspended_o,
  input logic        desc_rd_o,
  input logic        desc_wr_o,
  input logic [63:0] desc_wdata_o,
  input logic        buf_req_o,
  input logic [15:0] buf_addr_o,
  input logic [12:0] buf_len_o,
  input logic        buf_gnt_i,
  input logic        tx_irq_o
);
  // R1
  rd_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_rd_o |=> !desc_rd_o);

  // R2
  susp_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    suspended_o |-> !(buf_req_o || desc_rd_o || desc_wr_o));

  // R6
  wb_own_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_wr_o |-> !desc_wdata_o[63]);

  // R7
  irq_wb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_irq_o |-> desc_wr_o);

  // R9
  busy_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_busy_o |-> !(buf_req_o || desc_rd_o || desc_wr_o || suspended_o));

  // R11
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || sw_rst_i)
    (buf_req_o && !buf_gnt_i) |=> (buf_req_o && $stable(buf_addr_o) && $stable(buf_len_o)));

  // R4
  one_access_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({desc_rd_o, desc_wr_o, buf_req_o}));
endmodule

bind tx_ring_walker tx_ring_walker_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sw_rst_i     (sw_rst_i),
  .rst_busy_o   (rst_busy_o),
  .suspended_o  (suspended_o),
  .desc_rd_o    (desc_rd_o),
  .desc_wr_o    (desc_wr_o),
  .desc_wdata_o (desc_wdata_o),
  .buf_req_o    (buf_req_o),
  .buf_addr_o   (buf_addr_o),
  .buf_len_o    (buf_len_o),
  .buf_gnt_i    (buf_gnt_i),
  .tx_irq_o     (tx_irq_o)
);

// File: tb/tx_ring_walker_tb_top.sv
module tx_ring_walker_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int RST_CYC    = 4;

  typedef struct packed {
    logic [12:0] b1;
    logic [12:0] b2;
    logic        fs;
    logic        ls;
    logic        ioc;
    logic        err;
    logic [1:0]  exp_n;
    logic [1:0]  exp_f;
    logic [1:0]  exp_l;
    logic        exp_irq;
    logic        exp_es;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{13'd64,   13'd0,   1'b1, 1'b1, 1'b1, 1'b0, 2'd1, 2'b01, 2'b01, 1'b1, 1'b0},
    '{13'd4096, 13'd100, 1'b1, 1'b1, 1'b0, 1'b0, 2'd2, 2'b01, 2'b10, 1'b0, 1'b0},
    '{13'd0,    13'd50,  1'b1, 1'b0, 1'b0, 1'b0, 2'd1, 2'b01, 2'b00, 1'b0, 1'b0},
    '{13'd0,    13'd0,   1'b1, 1'b1, 1'b1, 1'b0, 2'd0, 2'b00, 2'b00, 1'b1, 1'b0},
    '{13'd200,  13'd30,  1'b0, 1'b1, 1'b1, 1'b1, 2'd2, 2'b00, 2'b10, 1'b1, 1'b1},
    '{13'd10,   13'd0,   1'b0, 1'b0, 1'b0, 1'b1, 2'd1, 2'b00, 2'b00, 1'b0, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] ring_base = '0;
  logic        start = 1'b0, poll = 1'b0, sw_rst = 1'b0;
  logic        rst_busy, suspended, desc_rd, desc_wr;
  logic [15:0] desc_addr;
  logic [63:0] desc_rdata = '0;
  logic [63:0] desc_wdata;
  logic        buf_req, buf_first, buf_last, buf_gnt, buf_err, tx_irq;
  logic [15:0] buf_addr;
  logic [12:0] buf_len;

  logic [63:0] mem [16];
  logic [15:0] rq_addr [256];
  logic [12:0] rq_len  [256];
  logic        rq_f    [256];
  logic        rq_l    [256];
  logic [15:0] rd_log  [256];
  int          rq_n = 0, rd_n = 0, irq_n = 0;
  int          gnt_wait = 0, wait_cnt = 0;
  logic        err_en = 1'b0;
  int          n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tx_ring_walker #(.IDX_W(8), .RST_CYCLES(RST_CYC)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ring_base_i(ring_base), .start_i(start),
    .poll_i(poll), .sw_rst_i(sw_rst), .rst_busy_o(rst_busy),
    .suspended_o(suspended), .desc_rd_o(desc_rd), .desc_wr_o(desc_wr),
    .desc_addr_o(desc_addr), .desc_rdata_i(desc_rdata), .desc_wdata_o(desc_wdata),
    .buf_req_o(buf_req), .buf_addr_o(buf_addr), .buf_len_o(buf_len),
    .buf_first_o(buf_first), .buf_last_o(buf_last), .buf_gnt_i(buf_gnt),
    .buf_err_i(buf_err), .tx_irq_o(tx_irq)
  );

  assign buf_gnt = buf_req && (wait_cnt >= gnt_wait);
  assign buf_err = buf_req && err_en && (buf_addr == 16'h0100);

  // memory model and monitors
  always @(posedge clk) begin
    if (desc_rd) desc_rdata <= mem[desc_addr[3:0]];
    if (desc_wr) mem[desc_addr[3:0]] <= desc_wdata;
    wait_cnt <= (buf_req && !buf_gnt) ? wait_cnt + 1 : 0;
    if (buf_req && buf_gnt) begin
      rq_addr[rq_n[7:0]] <= buf_addr;
      rq_len[rq_n[7:0]]  <= buf_len;
      rq_f[rq_n[7:0]]    <= buf_first;
      rq_l[rq_n[7:0]]    <= buf_last;
      rq_n <= rq_n + 1;
    end
    if (desc_rd) begin
      rd_log[rd_n[7:0]] <= desc_addr;
      rd_n <= rd_n + 1;
    end
    if (tx_irq) irq_n <= irq_n + 1;
  end

  function automatic logic [63:0] mk(logic own, logic wrap, logic fs, logic ls, logic ioc,
                                     logic [12:0] b2, logic [12:0] b1,
                                     logic [15:0] a2, logic [15:0] a1);
    return {own, wrap, fs, ls, ioc, 1'b0, b2, b1, a2, a1};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1'b1;
    @(negedge clk); s = 1'b0;
  endtask

  task automatic wait_susp();
    int t = 0;
    while (!suspended && t < 500) begin @(negedge clk); t++; end
    chk(suspended, "R2 suspend reached", 64'(suspended), 64'd1);
  endtask

  task automatic finish_tb();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_tb();
  end

  initial begin
    logic [63:0] d, exp_wb;
    int n0, r0, i0;
    for (int k = 0; k < 16; k++) mem[k] = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk({rst_busy, suspended, desc_rd, desc_wr, buf_req, buf_first, buf_last, tx_irq} == 8'h0,
        "R10 outputs in reset", 64'({rst_busy, suspended, desc_rd, desc_wr, buf_req, tx_irq}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({rst_busy, suspended, desc_rd, desc_wr, buf_req, tx_irq} == 6'h0,
        "R10 idle after reset", 64'({rst_busy, suspended, desc_rd, desc_wr, buf_req, tx_irq}), 64'd0);

    // vector table: one wrapping descriptor at base 4 per entry
    ring_base = 16'd4;
    for (int i = 0; i < 6; i++) begin
      gnt_wait = i % 3;
      err_en   = VECS[i].err;
      d = mk(1'b1, 1'b1, VECS[i].fs, VECS[i].ls, VECS[i].ioc, VECS[i].b2, VECS[i].b1,
             16'h0200, 16'h0100);
      mem[4] = d;
      n0 = rq_n; r0 = rd_n; i0 = irq_n;
      if (i == 0) pulse(start); else pulse(poll);
      wait_susp();
      // R4 R11: request count and contents under grant delay
      chk(rq_n - n0 == int'(VECS[i].exp_n), "R4 R11 request count", 64'(rq_n - n0), 64'(VECS[i].exp_n));
      for (int k = 0; k < int'(VECS[i].exp_n); k++) begin
        logic [15:0] ea;
        logic [12:0] el;
        if (k == 0 && VECS[i].b1 != 0) begin ea = 16'h0100; el = VECS[i].b1; end
        else begin ea = 16'h0200; el = VECS[i].b2; end
        chk(rq_addr[8'(n0+k)] == ea && rq_len[8'(n0+k)] == el, "R4 buffer addr/len",
            {rq_addr[8'(n0+k)], 3'b0, rq_len[8'(n0+k)]}, {ea, 3'b0, el});
        chk(rq_f[8'(n0+k)] == VECS[i].exp_f[k] && rq_l[8'(n0+k)] == VECS[i].exp_l[k],
            "R5 first/last flags", 64'({rq_f[8'(n0+k)], rq_l[8'(n0+k)]}),
            64'({VECS[i].exp_f[k], VECS[i].exp_l[k]}));
      end
      chk(irq_n - i0 == int'(VECS[i].exp_irq), "R7 interrupt count", 64'(irq_n - i0), 64'(VECS[i].exp_irq));
      exp_wb = d;
      exp_wb[63] = 1'b0;
      exp_wb[58] = VECS[i].exp_es;
      chk(mem[4] == exp_wb, "R6 write-back word", mem[4], exp_wb);
      chk(rd_n - r0 == 2 && rd_log[8'(r0)] == 16'd4 && rd_log[8'(r0+1)] == 16'd4,
          (i == 0) ? "R1 first read at base" : "R8 wrap reread at base",
          {rd_log[8'(r0)], rd_log[8'(r0+1)]}, {16'd4, 16'd4});
    end
    err_en = 1'b0;
    gnt_wait = 0;

    // R9 software reset while suspended; start during busy ignored
    r0 = rd_n;
    begin
      int busy_cnt = 0;
      @(negedge clk); sw_rst = 1'b1;
      @(negedge clk); sw_rst = 1'b0; start = 1'b1;
      ring_base = 16'd8;
      while (rst_busy && busy_cnt < 20) begin
        busy_cnt++;
        @(negedge clk); start = 1'b0;
      end
      start = 1'b0;
      chk(busy_cnt == RST_CYC, "R9 busy duration", 64'(busy_cnt), 64'(RST_CYC));
      repeat (2) @(negedge clk);
      chk(rd_n == r0 && !suspended, "R9 no access, not suspended", 64'(rd_n - r0), 64'd0);
    end

    // R8 multi-descriptor ring at base 8 with wrap on entry 10
    mem[8]  = mk(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 13'd0, 13'd16, 16'h0, 16'h0300);
    mem[9]  = mk(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 13'd0, 13'd16, 16'h0, 16'h0310);
    mem[10] = mk(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 13'd0, 13'd16, 16'h0, 16'h0320);
    mem[11] = mk(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 13'd0, 13'd16, 16'h0, 16'h0330);
    n0 = rq_n; r0 = rd_n; i0 = irq_n;
    pulse(start);
    wait_susp();
    chk(rd_n - r0 == 4 && rd_log[8'(r0)] == 16'd8 && rd_log[8'(r0+1)] == 16'd9 &&
        rd_log[8'(r0+2)] == 16'd10 && rd_log[8'(r0+3)] == 16'd8, "R8 ring walk order",
        {rd_log[8'(r0)], rd_log[8'(r0+1)], rd_log[8'(r0+2)], rd_log[8'(r0+3)]},
        {16'd8, 16'd9, 16'd10, 16'd8});
    chk(rq_n - n0 == 3 && rq_addr[8'(n0+2)] == 16'h0320, "R8 no request past wrap",
        64'(rq_n - n0), 64'd3);
    chk(mem[11][63] == 1'b1 && mem[10][63] == 1'b0, "R8 entry past wrap untouched",
        64'({mem[11][63], mem[10][63]}), 64'b10);
    chk(irq_n - i0 == 1, "R7 one interrupt on ring", 64'(irq_n - i0), 64'd1);

    // R2 R3 suspend mid-ring and resume at same index
    pulse(sw_rst);
    repeat (RST_CYC + 1) @(negedge clk);
    ring_base = 16'd0;
    mem[0] = mk(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 13'd0, 13'd8, 16'h0, 16'h0400);
    mem[1] = mk(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 13'd0, 13'd8, 16'h0, 16'h0410);
    n0 = rq_n; r0 = rd_n;
    pulse(start);
    wait_susp();
    repeat (5) @(negedge clk);
    chk(rd_n - r0 == 2 && rd_log[8'(r0+1)] == 16'd1 && suspended, "R2 stop at unowned entry",
        64'(rd_n - r0), 64'd2);
    chk(rq_n - n0 == 1 && mem[1][63] == 1'b0 && mem[1][58] == 1'b0, "R2 no request or write-back",
        64'(rq_n - n0), 64'd1);
    mem[1][63] = 1'b1;
    r0 = rd_n; n0 = rq_n;
    pulse(poll);
    wait_susp();
    chk(rd_log[8'(r0)] == 16'd1, "R3 resume at same index", 64'(rd_log[8'(r0)]), 64'd1);
    chk(rq_n - n0 == 1 && rq_addr[8'(n0)] == 16'h0410, "R3 resumed request",
        64'(rq_addr[8'(n0)]), 64'h0410);
    chk(rd_log[8'(r0+1)] == 16'd0, "R8 wrap after resume", 64'(rd_log[8'(r0+1)]), 64'd0);

    finish_tb();
  end
endmodule